// File: doc/BRIEF.md
# Program Sequencer with Forward Calls and Return Stack

This block keeps the execution position of a small processor that runs a fixed-size program as an endless ring. Each cycle in which an instruction retires, the sequencer is told what kind of control-flow operation it was, whether its condition held, the 64-bit operand A and an 8-bit immediate. From these it produces the index of the next instruction to fetch, a result word for return operations, and a flag that is raised once the instruction budget is used up.

Calls only ever jump forward. The jump distance is either taken straight from the immediate or mixed with the top byte of A. Each call saves two 64-bit words on an on-chip stack: the operand A first, then the byte address of the instruction after the call. A return removes both words in the reverse order. It jumps to the saved address and yields A XOR the saved operand. The stack has a fixed number of entries. When it is full, new words overwrite the oldest ones. A return that finds too few words behaves like an ordinary instruction.

The downstream pipeline uses `fetch_idx_o` to address the program store. It treats `done_o` as the end of the run. `ret_c_o` is written back wherever the return's result is destined.

Top module: `flow_seq_top`

## Requirements
- R1: While reset is applied and after it is released, `fetch_idx_o` is 0, `ret_c_o` is 0 and `done_o` is 0.
- R2: An executed step with `op_i` = 0 (plain), or with any `op_i` and `taken_i` = 0, moves `fetch_idx_o` to the next index modulo PROG_LEN; index PROG_LEN-1 is followed by 0.
- R3: An executed taken call (`op_i` = 1) moves `fetch_idx_o` forward by `imm0_i` + 1 modulo PROG_LEN.
- R4: An executed taken data call (`op_i` = 2) moves `fetch_idx_o` forward by (`imm0_i` XOR `opnd_a_i[63:56]`) + 1 modulo PROG_LEN.
- R5: Both call kinds push `opnd_a_i` and then 8 × (index after the call, modulo PROG_LEN). An executed taken return (`op_i` = 3) pops the address and then the value. It sets `ret_c_o` to `opnd_a_i` XOR value and `fetch_idx_o` to address bits [IDXW+2:3].
- R6: A taken return with fewer than two words on the stack sets `ret_c_o` to `opnd_a_i` and advances `fetch_idx_o` by one. A return with `taken_i` = 0 does the same.
- R7: The stack holds STK_DEPTH words. Pushing beyond that discards the oldest words, so at most STK_DEPTH/2 returns succeed after any burst of calls.
- R8: The budget starts at IC_INIT (65536). Each executed step uses one unit. `done_o` rises after the last unit is used. From then on steps change neither `fetch_idx_o` nor `ret_c_o`, and `done_o` stays high.
- R9: In a cycle with `step_i` = 0, no output or internal state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | An instruction retires this cycle |
| op_i | input | 2 | 0 plain, 1 call, 2 data call, 3 return |
| taken_i | input | 1 | Condition of the control-flow operation held |
| opnd_a_i | input | 64 | Operand A |
| imm0_i | input | 8 | Jump immediate |
| fetch_idx_o | output | IDXW (10) | Index of the next instruction to fetch |
| ret_c_o | output | 64 | Result of the latest executed return |
| done_o | output | 1 | Instruction budget exhausted |

## Verification
The assertions take the inputs to be known (not X) whenever `step_i` is high, with `op_i` used as a 2-bit code whose four values are all legal. The properties on the stack-empty return depend on the sequencer's internal empty indication. Every property looks only one cycle ahead. The stimulus is driven away from the clock edge, and all codes, immediates and operands are chosen freely, including bursts that overfill the stack and returns on an empty stack. It keeps stepping until the budget runs out and then beyond that point.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;
  typedef enum logic [1:0] {
    FOP_PLAIN = 2'd0,
    FOP_CALL  = 2'd1,
    FOP_DCALL = 2'd2,
    FOP_RET   = 2'd3
  } flow_op_e;

  localparam int WORD_W = 64;
endpackage

// File: rtl/flow_seq_stack.sv
// Circular two-word push / two-word pop stack. DEPTH must be an even power of two.
module flow_seq_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] first_i,
  input  logic [W-1:0] second_i,
  output logic [W-1:0] top_o,
  output logic [W-1:0] under_o,
  output logic         short_o
);
  localparam int PW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wp_q, wp_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            upd;

  always_comb begin
    wp_d  = wp_q;
    cnt_d = cnt_q;
    upd   = 1'b0;
    if (push_i) begin
      upd  = 1'b1;
      wp_d = wp_q + PW'(2);
      if (cnt_q >= CNTW'(DEPTH - 2)) cnt_d = CNTW'(DEPTH);
      else                           cnt_d = cnt_q + CNTW'(2);
    end else if (pop_i) begin
      upd   = 1'b1;
      wp_d  = wp_q - PW'(2);
      cnt_d = cnt_q - CNTW'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      mem[wp_q]          <= first_i;
      mem[wp_q + PW'(1)] <= second_i;
    end
  end

  assign top_o   = mem[wp_q - PW'(1)];
  assign under_o = mem[wp_q - PW'(2)];
  assign short_o = (cnt_q < CNTW'(2));
endmodule

// File: rtl/flow_seq_budget.sv
module flow_seq_budget #(
  parameter int IC_INIT = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic done_o
);
  localparam int ICW = $clog2(IC_INIT + 1);

  logic [ICW-1:0] ic_q, ic_d;
  logic           ic_en;

  always_comb begin
    ic_en = step_i && (ic_q != '0);
    ic_d  = ic_q - ICW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ic_q <= ICW'(IC_INIT);
    else if (ic_en) ic_q <= ic_d;
  end

  assign done_o = (ic_q == '0);
endmodule

// File: rtl/flow_seq_target.sv
module flow_seq_target
  import flow_seq_pkg::*;
#(
  parameter int IDXW = 10
) (
  input  logic [IDXW-1:0] cur_i,
  input  flow_op_e        op_i,
  input  logic            go_i,
  input  logic            taken_i,
  input  logic            short_i,
  input  logic [7:0]      a_top_i,
  input  logic [7:0]      imm0_i,
  input  logic [IDXW-1:0] back_i,
  output logic [IDXW-1:0] nxt_o,
  output logic [IDXW-1:0] seq_o,
  output logic            push_o,
  output logic            pop_o
);
  logic [7:0] hop;

  always_comb begin
    seq_o  = cur_i + IDXW'(1);
    hop    = (op_i == FOP_DCALL) ? (imm0_i ^ a_top_i) : imm0_i;
    nxt_o  = cur_i;
    push_o = 1'b0;
    pop_o  = 1'b0;
    if (go_i) begin
      nxt_o = seq_o;
      if (taken_i) begin
        unique case (op_i)
          FOP_CALL, FOP_DCALL: begin
            nxt_o  = cur_i + IDXW'(hop) + IDXW'(1);
            push_o = 1'b1;
          end
          FOP_RET: begin
            if (!short_i) begin
              nxt_o = back_i;
              pop_o = 1'b1;
            end
          end
          default: nxt_o = seq_o;
        endcase
      end
    end
  end
endmodule

// File: rtl/flow_seq_top.sv
module flow_seq_top
  import flow_seq_pkg::*;
#(
  parameter  int PROG_LEN  = 1024,
  parameter  int STK_DEPTH = 16,
  parameter  int IC_INIT   = 65536,
  localparam int IDXW      = $clog2(PROG_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic [1:0]      op_i,
  input  logic            taken_i,
  input  logic [63:0]     opnd_a_i,
  input  logic [7:0]      imm0_i,
  output logic [IDXW-1:0] fetch_idx_o,
  output logic [63:0]     ret_c_o,
  output logic            done_o
);
  flow_op_e          op;
  logic              go;
  logic              push, pop, stk_empty;
  logic [IDXW-1:0]   pc_q, pc_d, seq_idx, back_idx;
  logic [WORD_W-1:0] top_w, under_w, link_w;
  logic [63:0]       c_q, c_d;
  logic              c_en;

  assign op = flow_op_e'(op_i);
  assign go = step_i && !done_o;

  flow_seq_budget #(.IC_INIT(IC_INIT)) u_budget (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .done_o(done_o)
  );

  assign link_w   = WORD_W'({seq_idx, 3'b000});
  assign back_idx = top_w[IDXW+2:3];

  flow_seq_stack #(.DEPTH(STK_DEPTH), .W(WORD_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
    .first_i(opnd_a_i), .second_i(link_w),
    .top_o(top_w), .under_o(under_w), .short_o(stk_empty)
  );

  flow_seq_target #(.IDXW(IDXW)) u_target (
    .cur_i(pc_q), .op_i(op), .go_i(go), .taken_i(taken_i),
    .short_i(stk_empty), .a_top_i(opnd_a_i[63:56]), .imm0_i(imm0_i),
    .back_i(back_idx), .nxt_o(pc_d), .seq_o(seq_idx),
    .push_o(push), .pop_o(pop)
  );

  always_comb begin
    c_en = go && (op == FOP_RET);
    c_d  = pop ? (opnd_a_i ^ under_w) : opnd_a_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      c_q  <= '0;
    end else begin
      if (go)   pc_q <= pc_d;
      if (c_en) c_q  <= c_d;
    end
  end

  assign fetch_idx_o = pc_q;
  assign ret_c_o     = c_q;
endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk #(
  parameter int IDXW = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step_i,
  input logic [1:0]      op_i,
  input logic            taken_i,
  input logic [63:0]     opnd_a_i,
  input logic [7:0]      imm0_i,
  input logic [IDXW-1:0] fetch_idx_o,
  input logic [63:0]     ret_c_o,
  input logic            done_o,
  input logic            stk_empty
);
  logic            live;
  logic [IDXW-1:0] seq_t, call_t, dcall_t;

  assign live    = step_i && !done_o;
  assign seq_t   = fetch_idx_o + IDXW'(1);
  assign call_t  = fetch_idx_o + IDXW'(imm0_i) + IDXW'(1);
  assign dcall_t = fetch_idx_o + IDXW'(imm0_i ^ opnd_a_i[63:56]) + IDXW'(1);

  // R2
  seq_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && ((op_i == 2'd0) || !taken_i) |=> fetch_idx_o == $past(seq_t));

  // R3
  call_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && taken_i && (op_i == 2'd1) |=> fetch_idx_o == $past(call_t));

  // R4
  dcall_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && taken_i && (op_i == 2'd2) |=> fetch_idx_o == $past(dcall_t));

  // R6
  ret_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && (op_i == 2'd3) && (stk_empty || !taken_i)
    |=> (ret_c_o == $past(opnd_a_i)) && (fetch_idx_o == $past(seq_t)));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o && $stable(fetch_idx_o) && $stable(ret_c_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(fetch_idx_o) && $stable(ret_c_o) && $stable(done_o));
endmodule

bind flow_seq_top flow_seq_chk #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_i(step_i), .op_i(op_i), .taken_i(taken_i),
  .opnd_a_i(opnd_a_i), .imm0_i(imm0_i), .fetch_idx_o(fetch_idx_o),
  .ret_c_o(ret_c_o), .done_o(done_o), .stk_empty(stk_empty)
);

// File: tb/flow_seq_top_tb.sv
module flow_seq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN  = 1024;
  localparam int DEPTH = 16;
  localparam int BUDGET = 65536;

  logic        clk, rst_n, step, taken;
  logic [1:0]  op;
  logic [63:0] a;
  logic [7:0]  imm;
  logic [9:0]  fetch;
  logic [63:0] c_out;
  logic        done;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  // reference model
  longint unsigned q[$];
  int              m_pc = 0;
  longint unsigned m_c = 0;
  int              m_ic = BUDGET;

  flow_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .step_i(step), .op_i(op), .taken_i(taken),
    .opnd_a_i(a), .imm0_i(imm), .fetch_idx_o(fetch), .ret_c_o(c_out), .done_o(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, longint unsigned act, longint unsigned exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    check(req, 64'(fetch), 64'(m_pc), "fetch_idx");
    check(req, c_out, m_c, "ret_c");
    check("R8", 64'(done), 64'(m_ic == 0), "done");
  endtask

  function automatic void model(bit s, bit [1:0] o, bit t, longint unsigned av, bit [7:0] im);
    longint unsigned ad, vl;
    if (!s || m_ic == 0) return;
    m_ic--;
    if (t && (o == 2'd1 || o == 2'd2)) begin
      q.push_back(av);
      q.push_back(longint'((m_pc + 1) % PLEN) * 8);
      while (q.size() > DEPTH) void'(q.pop_front());
      if (o == 2'd1) m_pc = (m_pc + im + 1) % PLEN;
      else           m_pc = (m_pc + (im ^ av[63:56]) + 1) % PLEN;
    end else if (o == 2'd3) begin
      if (t && q.size() >= 2) begin
        ad = q.pop_back();
        vl = q.pop_back();
        m_c  = av ^ vl;
        m_pc = int'((ad >> 3) % PLEN);
      end else begin
        m_c  = av;
        m_pc = (m_pc + 1) % PLEN;
      end
    end else begin
      m_pc = (m_pc + 1) % PLEN;
    end
  endfunction

  task automatic step1(string req, bit s, bit [1:0] o, bit t, longint unsigned av, bit [7:0] im);
    step = s; op = o; taken = t; a = av; imm = im;
    @(posedge clk);
    model(s, o, t, av, im);
    @(negedge clk);
    compare(req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=200000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step = 0; op = 0; taken = 0; a = '0; imm = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2 plain and not-taken steps
    step1("R2", 1, 2'd0, 0, 64'h1, 8'h0);
    step1("R2", 1, 2'd0, 1, 64'h2, 8'h7);
    step1("R2", 1, 2'd1, 0, 64'h3, 8'h40);
    // R3 call
    step1("R3", 1, 2'd1, 1, 64'hAAAA_0000_0000_1111, 8'd5);
    // R4 data call: F0 ^ 0F = FF -> +256
    step1("R4", 1, 2'd2, 1, 64'hF000_0000_0000_2222, 8'h0F);
    // R9 idle
    step1("R9", 0, 2'd1, 1, 64'h5, 8'h9);
    step1("R9", 0, 2'd3, 1, 64'h6, 8'h9);
    // R5 returns
    step1("R5", 1, 2'd3, 1, 64'h0F0F_0F0F_0F0F_0F0F, 8'h0);
    step1("R5", 1, 2'd3, 1, 64'h1234_5678_9ABC_DEF0, 8'h0);
    // R6 empty and not-taken return
    step1("R6", 1, 2'd3, 1, 64'hDEAD_BEEF_0000_0001, 8'h0);
    step1("R3", 1, 2'd1, 1, 64'h77, 8'd1);
    step1("R6", 1, 2'd3, 0, 64'h55, 8'h0);
    step1("R5", 1, 2'd3, 1, 64'h66, 8'h0);
    // R7 overfill then unwind
    for (int i = 0; i < 12; i++)
      step1("R7", 1, 2'(1 + (i % 2)), 1, 64'h1000 + 64'(i) * 64'h0101_0000_0000_0001, 8'(i * 3));
    for (int i = 0; i < 9; i++)
      step1("R7", 1, 2'd3, 1, 64'h9000 + 64'(i), 8'h0);
    // R2 wrap through the ring end
    for (int i = 0; i < 5; i++)
      step1("R3", 1, 2'd1, 1, 64'h0, 8'd255);
    for (int i = 0; i < 8; i++)
      step1("R2", 1, 2'd0, 0, 64'h0, 8'h0);

    // mixed traffic until the budget is spent
    while (m_ic > 0) begin
      automatic bit [1:0] o = 2'($urandom_range(0, 3));
      automatic string tg = (o == 2'd3) ? "R5" : (o == 2'd2) ? "R4" : (o == 2'd1) ? "R3" : "R2";
      step1(tg, ($urandom_range(0, 7) != 0), o, ($urandom_range(0, 3) != 0),
            {$urandom, $urandom}, 8'($urandom));
    end
    // R8 steps after exhaustion
    for (int i = 0; i < 6; i++)
      step1("R8", 1, 2'(i % 4), 1, 64'hCAFE + 64'(i), 8'(i));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule